// File: doc/BRIEF.md
# LPI Configuration Register Block

This block holds the registers an interrupt controller uses to set up locality-specific peripheral interrupts (LPIs) for a single redistributor. Software reaches it through a simple register bus. It reads a distributor type word, a redistributor control word, a redistributor type word and a waker word. It also reads and writes two 64-bit base registers, one for the LPI property table and one for the LPI pending table. Static inputs report whether the LPI feature exists, whether security is active, and which affinity-routing enables are set.

The block decodes the stored state into outputs that the table-walking logic uses: an LPI enable, the effective interrupt identifier width, a flag that says the property table has a usable length, and the byte base address of each table. Accesses are 32-bit or 64-bit, chosen by `size64`. A write takes effect at the clock edge where `wr` is high. Read data appears on `rdata` after the clock edge where `rd` is high, and it holds until the next read.

Top module: `lpi_cfg_regs`

## Requirements
- R1: The distributor type word at offset 0x00 reads with bits 25 and 24 set, bit 10 equal to `sec_active`, bits [23:19] equal to 0xF, bits [4:0] equal to the interrupt-line parameter (default 7), and every other bit zero except bit 17.
- R2: Bit 17 of the distributor type word is 1 only when `lpi_present` is 1 and the routing enable in use is 1. That enable is `are_ns` when `sec_active` is 1, and `are` otherwise.
- R3: Bits [15:11] of the distributor type word always read zero.
- R4: Bit 0 of the redistributor control word at 0x10 is the LPI enable. A write sets or clears it only when `lpi_present` is 1; otherwise the write has no effect. All other bits read zero. `lpi_en` follows bit 0.
- R5: The redistributor type word at 0x18 reads `lpi_present` in bit 0 and zero elsewhere. In the waker word at 0x1C, only bits 2 and 1 are stored; all other bits read zero.
- R6: The property base register at 0x20 stores only bits [4:0], [11:7], [51:12] and [58:56] (mask 0x070F_FFFF_FFFF_FF9F). The pending base register at 0x28 stores only bits [11:7], [51:16], [58:56] and 62 (mask 0x470F_FFFF_FFFF_0F80). Other bits read zero.
- R7: The identifier-bits field, property base bits [4:0], reads back exactly as written. `id_width` equals the smaller of that field and 15.
- R8: `tbl_valid` is 1 exactly when the stored identifier-bits field is 13 or more.
- R9: A 32-bit write to a base register offset replaces only bits [31:0]. A 32-bit write to offset+4 replaces only bits [63:32]. A 64-bit write at the base offset replaces the whole register. A 32-bit read at offset+4 returns bits [63:32].
- R10: After reset, both base registers and the LPI enable are zero, and the waker word reads 0x6.
- R11: A read from an unmapped offset returns zero, and a write to it changes no register. A 64-bit access at offset+4 of a base register counts as unmapped.
- R12: `prop_base` is property bits [51:12] followed by 12 zero bits. `pend_base` is pending bits [51:16] followed by 16 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Byte offset of the access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| size64 | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| wdata | input | 64 | Write data (bits [31:0] for 32-bit accesses) |
| rdata | output | 64 | Registered read data |
| lpi_present | input | 1 | The LPI feature exists |
| sec_active | input | 1 | Security is active |
| are_ns | input | 1 | Non-secure affinity-routing enable |
| are | input | 1 | Affinity-routing enable used when security is off |
| lpi_en | output | 1 | LPIs are enabled at the redistributor |
| id_width | output | 5 | Effective identifier-bits value |
| tbl_valid | output | 1 | The property table has a usable length |
| prop_base | output | 52 | Byte base address of the property table |
| pend_base | output | 52 | Byte base address of the pending table |

## Verification
A wrong stored bit in a base register appears one cycle after the write. It shows as a wrong `prop_base`, `pend_base`, `id_width` or `tbl_valid`, or as wrong read data on the next read of either word. A write that leaks into the unwritten half, or into an unmapped offset, shows only when that half is read back or when the decoded outputs move. The bench therefore compares the decoded outputs against its own model on every clock. A control bit that is wrongly writable appears on `lpi_en` in the next cycle.

// File: rtl/lpi_cfg_regs.sv
module lpi_cfg_regs #(
  parameter int         AW       = 8,
  parameter logic [4:0] LINES    = 5'd7,
  parameter logic [4:0] DIST_IDB = 5'd15,
  parameter logic [4:0] MIN_IDB  = 5'd13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          size64,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata,
  input  logic          lpi_present,
  input  logic          sec_active,
  input  logic          are_ns,
  input  logic          are,
  output logic          lpi_en,
  output logic [4:0]    id_width,
  output logic          tbl_valid,
  output logic [51:0]   prop_base,
  output logic [51:0]   pend_base
);

  localparam logic [AW-1:0] A_DTYPE   = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL    = AW'(8'h10);
  localparam logic [AW-1:0] A_RTYPE   = AW'(8'h18);
  localparam logic [AW-1:0] A_WAKE    = AW'(8'h1C);
  localparam logic [AW-1:0] A_PROP    = AW'(8'h20);
  localparam logic [AW-1:0] A_PROP_HI = AW'(8'h24);
  localparam logic [AW-1:0] A_PEND    = AW'(8'h28);
  localparam logic [AW-1:0] A_PEND_HI = AW'(8'h2C);
  localparam logic [63:0] PROP_MASK = 64'h070F_FFFF_FFFF_FF9F;
  localparam logic [63:0] PEND_MASK = 64'h470F_FFFF_FFFF_0F80;

  logic        en_q;
  logic [1:0]  wake_q;
  logic [63:0] prop_q, pend_q;
  logic        lpi_sup;
  logic [31:0] dtype;
  logic [63:0] rd_val;

  logic hit_ctrl, hit_wake, hit_prop, hit_prop_hi, hit_pend, hit_pend_hi, mapped;

  assign hit_ctrl    = addr == A_CTRL;
  assign hit_wake    = addr == A_WAKE;
  assign hit_prop    = addr == A_PROP;
  assign hit_prop_hi = (addr == A_PROP_HI) && !size64;
  assign hit_pend    = addr == A_PEND;
  assign hit_pend_hi = (addr == A_PEND_HI) && !size64;
  assign mapped = (addr == A_DTYPE) || (addr == A_RTYPE) || hit_ctrl || hit_wake ||
                  hit_prop || hit_prop_hi || hit_pend || hit_pend_hi;

  assign lpi_sup = lpi_present && (sec_active ? are_ns : are);
  assign dtype = {6'b0, 2'b11, DIST_IDB, 1'b0, lpi_sup, 1'b0, 5'b0,
                  sec_active, 5'b0, LINES};

  always_comb begin
    rd_val = '0;
    case (1'b1)
      addr == A_DTYPE: rd_val = {32'b0, dtype};
      hit_ctrl:        rd_val = {63'b0, en_q};
      addr == A_RTYPE: rd_val = {63'b0, lpi_present};
      hit_wake:        rd_val = {61'b0, wake_q, 1'b0};
      hit_prop:        rd_val = size64 ? prop_q : {32'b0, prop_q[31:0]};
      hit_prop_hi:     rd_val = {32'b0, prop_q[63:32]};
      hit_pend:        rd_val = size64 ? pend_q : {32'b0, pend_q[31:0]};
      hit_pend_hi:     rd_val = {32'b0, pend_q[63:32]};
      default:         rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wake_q <= 2'b11;
      prop_q <= '0;
      pend_q <= '0;
      rdata  <= '0;
    end else begin
      if (rd) rdata <= rd_val;
      if (wr) begin
        if (hit_ctrl && lpi_present) en_q <= wdata[0];
        if (hit_wake) wake_q <= wdata[2:1];
        if (hit_prop) begin
          if (size64) prop_q <= wdata & PROP_MASK;
          else        prop_q[31:0] <= wdata[31:0] & PROP_MASK[31:0];
        end
        if (hit_prop_hi) prop_q[63:32] <= wdata[31:0] & PROP_MASK[63:32];
        if (hit_pend) begin
          if (size64) pend_q <= wdata & PEND_MASK;
          else        pend_q[31:0] <= wdata[31:0] & PEND_MASK[31:0];
        end
        if (hit_pend_hi) pend_q[63:32] <= wdata[31:0] & PEND_MASK[63:32];
      end
    end
  end

  assign lpi_en    = en_q;
  assign id_width  = (prop_q[4:0] > DIST_IDB) ? DIST_IDB : prop_q[4:0];
  assign tbl_valid = prop_q[4:0] >= MIN_IDB;
  assign prop_base = {prop_q[51:12], 12'h000};
  assign pend_base = {pend_q[51:16], 16'h0000};

  assert_ctrl_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lpi_present |=> $stable(lpi_en));

  assert_width_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_width <= DIST_IDB);

  assert_valid_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_valid |-> id_width >= MIN_IDB);

  assert_low_write_keeps_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !size64 && addr == A_PROP) |=> prop_base[51:32] == $past(prop_base[51:32]));

  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !mapped) |=> ($stable(prop_base) && $stable(pend_base) &&
                         $stable(lpi_en) && $stable(id_width)));

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |=> rdata == 64'h0);

endmodule

// File: tb/lpi_cfg_regs_test.sv
module lpi_cfg_regs_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        rd = 0, wr = 0, size64 = 0;
  logic [63:0] wdata = 0;
  logic [63:0] rdata;
  logic        lpi_present = 0, sec_active = 0, are_ns = 0, are = 0;
  logic        lpi_en, tbl_valid;
  logic [4:0]  id_width;
  logic [51:0] prop_base, pend_base;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_prop, m_pend;
  logic        m_en;
  logic [1:0]  m_wk;
  localparam logic [63:0] PM = 64'h070F_FFFF_FFFF_FF9F;
  localparam logic [63:0] DM = 64'h470F_FFFF_FFFF_0F80;

  lpi_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .size64(size64),
    .wdata(wdata), .rdata(rdata), .lpi_present(lpi_present), .sec_active(sec_active),
    .are_ns(are_ns), .are(are), .lpi_en(lpi_en), .id_width(id_width),
    .tbl_valid(tbl_valid), .prop_base(prop_base), .pend_base(pend_base));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mread(input logic [7:0] a, input logic sz);
    logic sup;
    sup = lpi_present && (sec_active ? are_ns : are);
    case (a)
      8'h00: mread = 64'((1 << 25) | (1 << 24) | (15 << 19) | (int'(sup) << 17) |
                          (int'(sec_active) << 10) | 7);
      8'h10: mread = {63'b0, m_en};
      8'h18: mread = {63'b0, lpi_present};
      8'h1C: mread = {61'b0, m_wk, 1'b0};
      8'h20: mread = sz ? m_prop : {32'b0, m_prop[31:0]};
      8'h24: mread = sz ? 64'h0 : {32'b0, m_prop[63:32]};
      8'h28: mread = sz ? m_pend : {32'b0, m_pend[31:0]};
      8'h2C: mread = sz ? 64'h0 : {32'b0, m_pend[63:32]};
      default: mread = 64'h0;
    endcase
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic sz, input logic [63:0] d);
    case (a)
      8'h10: if (lpi_present) m_en = d[0];
      8'h1C: m_wk = d[2:1];
      8'h20: if (sz) m_prop = d & PM; else m_prop[31:0] = d[31:0] & PM[31:0];
      8'h24: if (!sz) m_prop[63:32] = d[31:0] & PM[63:32];
      8'h28: if (sz) m_pend = d & DM; else m_pend[31:0] = d[31:0] & DM[31:0];
      8'h2C: if (!sz) m_pend[63:32] = d[31:0] & DM[63:32];
      default: ;
    endcase
  endtask

  task automatic do_wr(input logic [7:0] a, input logic sz, input logic [63:0] d);
    @(negedge clk);
    addr = a; size64 = sz; wdata = d; wr = 1;
    @(posedge clk);
    #1 mwrite(a, sz, d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic sz, input string req);
    @(negedge clk);
    addr = a; size64 = sz; rd = 1;
    @(negedge clk);
    rd = 0;
    check(req, rdata, mread(a, sz));
  endtask

  // per-clock comparison of decoded outputs: R4 R7 R8 R12
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R4 lpi_en", {63'b0, lpi_en}, {63'b0, m_en});
      check("R7 id_width", {59'b0, id_width}, (m_prop[4:0] > 5'd15) ? 64'd15 : {59'b0, m_prop[4:0]});
      check("R8 tbl_valid", {63'b0, tbl_valid}, {63'b0, m_prop[4:0] >= 5'd13});
      check("R12 prop_base", {12'b0, prop_base}, {12'b0, m_prop[51:12], 12'h000});
      check("R12 pend_base", {12'b0, pend_base}, {12'b0, m_pend[51:16], 16'h0000});
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_prop = 0; m_pend = 0; m_en = 0; m_wk = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    do_rd(8'h20, 1, "R10 prop reset");
    do_rd(8'h28, 1, "R10 pend reset");
    do_rd(8'h1C, 0, "R10 waker reset");
    do_rd(8'h10, 0, "R10 ctrl reset");
    // R1 R2 R3 type word under input combinations
    for (int k = 0; k < 16; k++) begin
      lpi_present = k[0]; sec_active = k[1]; are_ns = k[2]; are = k[3];
      do_rd(8'h00, 0, "R1 R2 R3 dist type");
      do_rd(8'h18, 0, "R5 redist type");
    end
    // R4 enable locked without LPI feature
    lpi_present = 0;
    do_wr(8'h10, 0, 64'hFFFF_FFFF);
    do_rd(8'h10, 0, "R4 ctrl ignored");
    lpi_present = 1;
    do_wr(8'h10, 0, 64'hFFFF_FFFF);
    do_rd(8'h10, 0, "R4 ctrl set");
    lpi_present = 0;
    do_wr(8'h10, 0, 64'h0);
    do_rd(8'h10, 0, "R4 ctrl clear ignored");
    lpi_present = 1;
    do_wr(8'h10, 0, 64'h0);
    do_rd(8'h10, 0, "R4 ctrl clear");
    // R5 waker
    do_wr(8'h1C, 0, 64'h0);
    do_rd(8'h1C, 0, "R5 waker zero");
    do_wr(8'h1C, 0, 64'hFFFF_FFFF);
    do_rd(8'h1C, 0, "R5 waker masked");
    // R6 masks
    do_wr(8'h20, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(8'h20, 1, "R6 prop mask");
    do_wr(8'h28, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(8'h28, 1, "R6 pend mask");
    // R7 R8 identifier width corners
    for (int v = 10; v < 32; v++) begin
      do_wr(8'h20, 0, 64'(v) | 64'h0001_2000);
      do_rd(8'h20, 0, "R7 idbits readback");
    end
    // R9 partial writes
    do_wr(8'h20, 1, 64'h0123_4567_89AB_CDEF);
    do_wr(8'h20, 0, 64'h0000_0000_1234_500E);
    do_rd(8'h20, 1, "R9 low word only");
    do_wr(8'h24, 0, 64'h0000_0000_0000_0ABC);
    do_rd(8'h20, 1, "R9 high word only");
    do_rd(8'h24, 0, "R9 high read");
    do_wr(8'h28, 0, 64'h0000_0000_FFFF_0380);
    do_wr(8'h2C, 0, 64'h4000_0001);
    do_rd(8'h2C, 0, "R9 pend high read");
    do_rd(8'h28, 1, "R9 pend full");
    // R11 unmapped
    do_wr(8'h40, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_wr(8'h24, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_wr(8'h2C, 1, 64'h0);
    do_rd(8'h40, 0, "R11 unmapped read");
    do_rd(8'h24, 1, "R11 wide high read");
    do_rd(8'h20, 1, "R11 prop unchanged");
    do_rd(8'h28, 1, "R11 pend unchanged");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule